// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a fast input clock by a programmable integer N and emits a one-cycle pulse once per division period. The pulse is meant for a phase comparator. The divider is built the way a synthesizer feedback path is built. A prescaler runs at modulus 33 or modulus 32. A swallow count A says how many prescaler periods use the longer modulus. A program count B says how many prescaler periods make up one output period. Together they give N = 32·B + A. The prescaler is modelled as synchronous logic in the same clock domain as the counters.

Software supplies A and B on plain input ports. The block checks every pair on each cycle. A legal pair is captured as the pending setting. An illegal pair raises a flag and is dropped, so the divider keeps running on the last legal pair. The pending setting is copied into the counters only at a load point. A load point is either the end of an output period or a cycle with the synchronous reset/load strobe high.

Top module: `swallow_fb_divider`

## Requirements
- R1: After the strobe falls, `div_pulse_o` is high only in the cycle that follows the N-th rising edge counted from the first edge with the strobe low. The pulse then repeats every N cycles and is exactly one cycle wide, with N = 32·B + A.
- R2: Each output period is made of B prescaler periods. The first A of them last 33 cycles and the remaining B−A last 32 cycles. With A = 0 the period is 32·B. With A = B the period is 33·B.
- R3: Every A from 0 to 31 is accepted, including A = 31 with any B of at least 31.
- R4: A pair with B below 3 is illegal. `cfg_err_o` is high in the cycle after such a pair is presented, and the divider keeps its previous period.
- R5: A pair with A greater than B is illegal. It is flagged and ignored in the same way as R4.
- R6: A legal pair that changes during an output period does not shorten or lengthen that period. It sets the length of the period that starts at the next load point. The counters reload from the pair that was pending one cycle before the period ends.
- R7: With the strobe high, the output is low and both counters sit at their load point with the pair on the inputs. A strobe in the middle of a period restarts counting, as described in R1.
- R8: If the pair on the inputs is illegal while the strobe is high, the divider loads its default pair, which is B = 4 and A = 0 (N = 128), and raises `cfg_err_o`.
- R9: `cfg_err_o` returns low in the cycle after a legal pair is presented again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous active-high reset and load strobe |
| swal_a_i | input | 5 | Swallow count A (number of modulus-33 periods) |
| prog_b_i | input | 13 | Program count B (prescaler periods per output period) |
| div_pulse_o | output | 1 | Registered one-cycle pulse, once every N cycles |
| cfg_err_o | output | 1 | Registered flag: the previous cycle's A/B pair was illegal |

## Verification
Assertions check the following on every cycle:
- The remaining swallow count never exceeds the remaining program count.
- The program count never reaches zero while the divider runs.
- The prescaler never reaches its 33rd state unless swallowing is in progress.
- The pending pair is always legal and stays frozen while the flag is up.
- The output pulse never lasts two cycles.

The exact period lengths, the A = 0 and A = B extremes, and the moment a changed pair takes effect are only visible to the bench. The bench compares the output against a behavioural period counter on every clock. It drives mid-period changes, illegal pairs, and reset strobes with legal and illegal inputs.

// File: rtl/swd_pkg.sv
package swd_pkg;
  localparam int SWD_A_W   = 5;
  localparam int SWD_B_W   = 13;
  localparam int SWD_B_MIN = 3;

  typedef enum logic {MOD_LO, MOD_HI} mod_e;
endpackage

// File: rtl/swd_cfg_hold.sv
module swd_cfg_hold
  import swd_pkg::*;
#(
  parameter int A_W   = SWD_A_W,
  parameter int B_W   = SWD_B_W,
  parameter int B_MIN = SWD_B_MIN,
  parameter int DEF_A = 0,
  parameter int DEF_B = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] b_in,
  output logic [A_W-1:0] held_a,
  output logic [B_W-1:0] held_b,
  output logic [A_W-1:0] seed_a,
  output logic [B_W-1:0] seed_b,
  output logic           err_o
);
  localparam logic [B_W-1:0] B_MIN_V = B_W'(B_MIN);
  localparam logic [A_W-1:0] DEF_A_V = A_W'(DEF_A);
  localparam logic [B_W-1:0] DEF_B_V = B_W'(DEF_B);

  logic pair_ok;

  // A pair is usable when B reaches the floor and A does not exceed B.
  always_comb begin
    pair_ok = (b_in >= B_MIN_V) && ({{(B_W-A_W){1'b0}}, a_in} <= b_in);
    seed_a  = pair_ok ? a_in : DEF_A_V;
    seed_b  = pair_ok ? b_in : DEF_B_V;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held_a <= seed_a;
      held_b <= seed_b;
    end else if (pair_ok) begin
      held_a <= a_in;
      held_b <= b_in;
    end
    err_o <= ~pair_ok;
  end

  // The pending pair must always be legal (R4, R5).
  p_held_legal_r4: assert property (@(posedge clk) disable iff (rst)
    (held_b >= B_MIN_V) && ({{(B_W-A_W){1'b0}}, held_a} <= held_b));

  // A flagged pair leaves the pending setting untouched (R5).
  p_flag_freezes_r5: assert property (@(posedge clk) disable iff (rst)
    (err_o && !$past(rst)) |-> (held_a == $past(held_a) && held_b == $past(held_b)));
endmodule

// File: rtl/swd_prescaler.sv
module swd_prescaler
  import swd_pkg::*;
#(
  parameter int A_W = SWD_A_W
) (
  input  logic clk,
  input  logic rst,
  input  logic swallow,
  output logic pre_tc
);
  localparam int PC_W = A_W + 1;
  localparam logic [PC_W-1:0] LAST_LO = PC_W'((1 << A_W) - 1);
  localparam logic [PC_W-1:0] LAST_HI = PC_W'(1 << A_W);

  mod_e            mod_sel;
  logic [PC_W-1:0] pc;

  always_comb begin
    mod_sel = swallow ? MOD_HI : MOD_LO;
    pre_tc  = (mod_sel == MOD_HI) ? (pc == LAST_HI) : (pc == LAST_LO);
  end

  always_ff @(posedge clk) begin
    if (rst || pre_tc) pc <= '0;
    else               pc <= pc + 1'b1;
  end

  // The extra state is reached only while swallowing (R2).
  p_no_extra_state_r2: assert property (@(posedge clk) disable iff (rst)
    !swallow |-> (pc != LAST_HI));

  p_pc_bound_r2: assert property (@(posedge clk) disable iff (rst)
    pc <= LAST_HI);
endmodule

// File: rtl/swd_count_pair.sv
module swd_count_pair
  import swd_pkg::*;
#(
  parameter int A_W = SWD_A_W,
  parameter int B_W = SWD_B_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [A_W-1:0] seed_a,
  input  logic [B_W-1:0] seed_b,
  input  logic [A_W-1:0] held_a,
  input  logic [B_W-1:0] held_b,
  input  logic           pre_tc,
  output logic           swallow,
  output logic           pulse_o
);
  logic [A_W-1:0] a_rem;
  logic [B_W-1:0] b_rem;
  logic           period_end;

  always_comb begin
    swallow    = (a_rem != '0);
    period_end = pre_tc && (b_rem == B_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_rem   <= seed_a;
      b_rem   <= seed_b;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= period_end;
      if (period_end) begin
        a_rem <= held_a;
        b_rem <= held_b;
      end else if (pre_tc) begin
        b_rem <= b_rem - 1'b1;
        if (swallow) a_rem <= a_rem - 1'b1;
      end
    end
  end

  // Swallowing always finishes within the program count (R2, R5).
  p_a_within_b_r2: assert property (@(posedge clk) disable iff (rst)
    {{(B_W-A_W){1'b0}}, a_rem} <= b_rem);

  p_b_alive_r1: assert property (@(posedge clk) disable iff (rst)
    b_rem != '0);

  p_single_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/swallow_fb_divider.sv
module swallow_fb_divider
  import swd_pkg::*;
#(
  parameter int A_W   = SWD_A_W,
  parameter int B_W   = SWD_B_W,
  parameter int B_MIN = SWD_B_MIN,
  parameter int DEF_A = 0,
  parameter int DEF_B = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [A_W-1:0] swal_a_i,
  input  logic [B_W-1:0] prog_b_i,
  output logic           div_pulse_o,
  output logic           cfg_err_o
);
  logic [A_W-1:0] held_a, seed_a;
  logic [B_W-1:0] held_b, seed_b;
  logic           swallow, pre_tc;

  swd_cfg_hold #(
    .A_W(A_W), .B_W(B_W), .B_MIN(B_MIN), .DEF_A(DEF_A), .DEF_B(DEF_B)
  ) u_cfg (
    .clk(clk), .rst(rst), .a_in(swal_a_i), .b_in(prog_b_i),
    .held_a(held_a), .held_b(held_b), .seed_a(seed_a), .seed_b(seed_b),
    .err_o(cfg_err_o)
  );

  swd_prescaler #(.A_W(A_W)) u_pre (
    .clk(clk), .rst(rst), .swallow(swallow), .pre_tc(pre_tc)
  );

  swd_count_pair #(.A_W(A_W), .B_W(B_W)) u_cnt (
    .clk(clk), .rst(rst), .seed_a(seed_a), .seed_b(seed_b),
    .held_a(held_a), .held_b(held_b), .pre_tc(pre_tc),
    .swallow(swallow), .pulse_o(div_pulse_o)
  );
endmodule

// File: tb/tb_swallow_fb_divider.sv
module tb_swallow_fb_divider;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  a_in = 5'd0;
  logic [12:0] b_in = 13'd3;
  logic        div_pulse_o, cfg_err_o;

  int checks = 0, errors = 0, cyc = 0;
  bit started = 0;
  string tag = "R7";

  // Behavioural reference state
  int  m_cnt = 0, m_n = 0, m_ha = 0, m_hb = 4;
  bit  m_pulse = 0, m_err = 0;

  always #10 clk = ~clk;

  swallow_fb_divider dut (
    .clk(clk), .rst(rst), .swal_a_i(a_in), .prog_b_i(b_in),
    .div_pulse_o(div_pulse_o), .cfg_err_o(cfg_err_o)
  );

  function automatic bit legal(int a, int b);
    return (b >= 3) && (a <= b);
  endfunction

  always @(posedge clk) begin
    bit ok;
    ok = legal(int'(a_in), int'(b_in));
    if (rst) begin
      m_ha = ok ? int'(a_in) : 0;
      m_hb = ok ? int'(b_in) : 4;
      m_n = 32 * m_hb + m_ha;
      m_cnt = 0;
      m_pulse = 0;
    end else begin
      m_cnt++;
      if (m_cnt == m_n) begin
        m_pulse = 1;
        m_cnt = 0;
        m_n = 32 * m_hb + m_ha;
      end else m_pulse = 0;
      if (ok) begin
        m_ha = int'(a_in);
        m_hb = int'(b_in);
      end
    end
    m_err = !ok;
    started = 1;
  end

  always @(negedge clk) begin
    cyc++;
    if (started) begin
      checks++;
      if (div_pulse_o !== m_pulse) begin
        errors++;
        $display("FAIL %s pulse at cycle %0d: got %b expected %b", tag, cyc, div_pulse_o, m_pulse);
      end
      checks++;
      if (cfg_err_o !== m_err) begin
        errors++;
        $display("FAIL %s flag at cycle %0d: got %b expected %b", tag, cyc, cfg_err_o, m_err);
      end
    end
    if (cyc > 200000) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setp(int a, int b);
    @(negedge clk);
    a_in = 5'(a);
    b_in = 13'(b);
  endtask

  initial begin
    // R7: reset state with the strobe high
    tag = "R7"; a_in = 5'd0; b_in = 13'd3;
    run(4);
    rst = 1'b0;
    // R1 and R2: A=0 gives 32*B
    tag = "R1_R2_a0";
    run(400);
    // R2: A=B gives 33*B
    tag = "R2_a_eq_b"; setp(3, 3);
    run(500);
    // R3: A at its maximum
    tag = "R3_a31"; setp(31, 40);
    run(3000);
    // R6: change in the middle of a period
    tag = "R6_midchange"; setp(5, 10);
    run(150);
    setp(2, 6);
    run(900);
    // R4: B below the floor is flagged and ignored
    tag = "R4_b_low"; setp(1, 2);
    run(600);
    // R5: A above B is flagged and ignored
    tag = "R5_a_gt_b"; setp(9, 8);
    run(500);
    // R9: the flag clears on a legal pair
    tag = "R9_clear"; setp(8, 8);
    run(600);
    // R7: reset in the middle of a period
    tag = "R7_midreset"; run(77);
    @(negedge clk); rst = 1'b1;
    run(2);
    @(negedge clk); rst = 1'b0;
    run(700);
    // R8: reset with an illegal pair loads the default
    tag = "R8_default"; @(negedge clk); a_in = 5'd20; b_in = 13'd1; rst = 1'b1;
    run(2);
    @(negedge clk); rst = 1'b0;
    run(500);
    tag = "R9_after_default"; setp(0, 5);
    run(800);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule